// File: doc/BRIEF.md
# Shared RAM Ownership Controller

This block holds the memory-mode control word for a 256 KB shared RAM that sits between a main CPU and a sub CPU, and decides which processor may reach which 128 KB half of that RAM. Each CPU has its own write strobe with write data, and its own read-data view of the control word. The two sides may write different fields. Ownership changes through a handshake. The sub CPU returns the RAM or picks the layout. The main CPU hands the RAM over with a grant flag.

Two layouts exist. In whole-RAM layout one processor holds both halves. In split layout each processor holds one half, and the return bit chooses which half goes to which side. The block drives a registered owner flag for each half and each side. It also drives the base offset that each side's RAM window maps to.

The same control word also selects which 128 KB bank of program RAM the main CPU sees. It carries one write-protect bit for each program-RAM region, and the block decodes these bits for sub CPU program writes. The RAM arrays themselves and the CPU bus timing live outside the block.

Top module: `shram_owner_ctrl`

## Requirements
- R1: After reset the control word is 0x0001: return bit (bit 0) is 1, every other bit is 0. The main CPU owns both halves and the sub CPU owns none.
- R2: A sub CPU write stores only the return bit (bit 0), the layout bit (bit 2, 0 = whole, 1 = split) and the two priority bits (bits 4:3). All other bits keep their value.
- R3: A main CPU write stores bits 15:6 and the grant bit (bit 1) as defined in R7/R8. Bits 0, 2, 4:3 keep their value. Bit 5 always reads as 0.
- R4: A sub CPU write that changes bit 0 or bit 2 clears the grant bit. A sub CPU write that changes neither leaves the grant bit as it was.
- R5: A sub CPU write that changes bit 0 or bit 2 while leaving whole layout assigns both halves as follows. With return = 1 the main CPU gets both. With return = 0 the sub CPU gets both.
- R6: A sub CPU write that changes bit 0 or bit 2 while leaving split layout assigns the halves as follows. With return = 1 the main CPU gets the upper half and the sub CPU the lower. With return = 0 the two are swapped. A side that owns only the upper half has window base 0x20000; any other side has base 0.
- R7: In whole layout a main CPU write stores its grant bit as written. If the write takes the grant bit from 0 to 1, both halves pass to the sub CPU.
- R8: In split layout a main CPU write stores the inverse of its grant bit, so writing 0 sets the grant bit to 1 and writing 1 sets it to 0. Ownership does not change.
- R9: The main CPU read returns the control word with bits 4:3 forced to 0. The sub CPU read returns it with bits 7:5 forced to 0.
- R10: A sub CPU program-RAM write to 128 KB region n (n = 0..3, from address bits 18:17) is allowed only when control bit 8+n is 0. No write is allowed without the write strobe.
- R11: The program bank base offset equals control bits 7:6 times 0x20000.
- R12: When both CPUs write in the same cycle, the sub CPU write is applied first. The main CPU fields are then merged onto that result, and the main CPU's layout and grant-edge decisions use the post-sub-write value.
- R13: Owner flags are registered: a write is visible on them after the next clock edge. No half ever has two owners.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_we | input | 1 | Main CPU control-word write strobe |
| main_wdata | input | 16 | Main CPU write data |
| main_rdata | output | 16 | Control word as seen by the main CPU |
| sub_we | input | 1 | Sub CPU control-word write strobe |
| sub_wdata | input | 16 | Sub CPU write data |
| sub_rdata | output | 16 | Control word as seen by the sub CPU |
| sub_prog_we | input | 1 | Sub CPU program-RAM write request |
| sub_prog_region | input | 2 | Program-RAM address bits selecting the 128 KB region |
| sub_prog_wr_ok | output | 1 | Program-RAM write permitted |
| prog_bank_base | output | 19 | Program-RAM bank base offset for the main CPU |
| main_hi | output | 1 | Main CPU owns the upper half |
| main_lo | output | 1 | Main CPU owns the lower half |
| sub_hi | output | 1 | Sub CPU owns the upper half |
| sub_lo | output | 1 | Sub CPU owns the lower half |
| main_win_base | output | 18 | Base offset of the main CPU window |
| sub_win_base | output | 18 | Base offset of the sub CPU window |

## Verification
A sub CPU layout or return change and a main CPU grant write can land in the same cycle. The result then depends on which of the two is taken as applied first. The bench provokes this with a sub write that moves from whole to split layout together with a main write of grant 0. Sub-first ordering gives grant 1 (the split-layout inversion), while main-first ordering would give grant 0. A queue-driven scoreboard judges the merged control word and the owner flags against a model built from the ordering rule. A second case pairs a return change with a grant rise to show that the ownership assignment from the main write wins.

// File: rtl/shram_pkg.sv
package shram_pkg;
    localparam int CTL_W     = 16;
    localparam int B_RET     = 0;
    localparam int B_GRANT   = 1;
    localparam int B_LAYOUT  = 2;
    localparam int B_ZERO    = 5;
    localparam int BANK_LSB  = 6;
    localparam int PROT_LSB  = 8;

    localparam logic [CTL_W-1:0] CTL_RESET   = 16'h0001;
    localparam logic [CTL_W-1:0] SUB_WMASK   = 16'h001D;
    localparam logic [CTL_W-1:0] MAIN_WMASK  = 16'hFFC0;
    localparam logic [CTL_W-1:0] MAIN_RMASK  = 16'hFFE7;
    localparam logic [CTL_W-1:0] SUB_RMASK   = 16'hFF1F;

    typedef struct packed {
        logic main_hi;
        logic main_lo;
        logic sub_hi;
        logic sub_lo;
    } own_t;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        own_t             own;
    } mode_state_t;

    localparam own_t OWN_MAIN_ALL = '{main_hi: 1'b1, main_lo: 1'b1, sub_hi: 1'b0, sub_lo: 1'b0};
    localparam own_t OWN_SUB_ALL  = '{main_hi: 1'b0, main_lo: 1'b0, sub_hi: 1'b1, sub_lo: 1'b1};
    localparam own_t OWN_MAIN_HI  = '{main_hi: 1'b1, main_lo: 1'b0, sub_hi: 1'b0, sub_lo: 1'b1};
    localparam own_t OWN_MAIN_LO  = '{main_hi: 1'b0, main_lo: 1'b1, sub_hi: 1'b1, sub_lo: 1'b0};

    function automatic own_t layout_owner(input logic layout, input logic ret);
        if (!layout) return ret ? OWN_MAIN_ALL : OWN_SUB_ALL;
        return ret ? OWN_MAIN_HI : OWN_MAIN_LO;
    endfunction
endpackage

// File: rtl/shram_mode_reg.sv
module shram_mode_reg
    import shram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_we,
    input  logic [CTL_W-1:0] main_wdata,
    input  logic             sub_we,
    input  logic [CTL_W-1:0] sub_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output own_t             own_q
);
    mode_state_t st_d, st_q;
    logic [CTL_W-1:0] mid_d;
    logic             flip_d;

    always_comb begin
        st_d   = st_q;
        mid_d  = st_q.ctl;
        flip_d = 1'b0;
        // sub CPU side first
        if (sub_we) begin
            mid_d  = (st_q.ctl & ~SUB_WMASK) | (sub_wdata & SUB_WMASK);
            flip_d = (mid_d[B_RET] != st_q.ctl[B_RET]) ||
                     (mid_d[B_LAYOUT] != st_q.ctl[B_LAYOUT]);
            if (flip_d) begin
                mid_d[B_GRANT] = 1'b0;
                st_d.own       = layout_owner(mid_d[B_LAYOUT], mid_d[B_RET]);
            end
        end
        st_d.ctl = mid_d;
        // main CPU side merged on top
        if (main_we) begin
            st_d.ctl = (mid_d & ~MAIN_WMASK) | (main_wdata & MAIN_WMASK);
            if (mid_d[B_LAYOUT]) begin
                st_d.ctl[B_GRANT] = ~main_wdata[B_GRANT];
            end else begin
                st_d.ctl[B_GRANT] = main_wdata[B_GRANT];
                if (!mid_d[B_GRANT] && main_wdata[B_GRANT]) begin
                    st_d.own = OWN_SUB_ALL;
                end
            end
        end
        st_d.ctl[B_ZERO] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl <= CTL_RESET;
            st_q.own <= OWN_MAIN_ALL;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;
    assign own_q = st_q.own;

    // R2
    sub_only_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_we && !main_we) |=> (ctl_q[15:5] == $past(ctl_q[15:5])));

    // R3
    main_only_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_we && !sub_we) |=> (ctl_q[4:2] == $past(ctl_q[4:2]) && ctl_q[0] == $past(ctl_q[0])));

    // R3
    bit5_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> !ctl_q[B_ZERO]);

    // R4
    grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_we && !main_we && ((sub_wdata[B_RET] != ctl_q[B_RET]) || (sub_wdata[B_LAYOUT] != ctl_q[B_LAYOUT])))
        |=> !ctl_q[B_GRANT]);

    // R8
    split_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_we && !sub_we && ctl_q[B_LAYOUT] && !main_wdata[B_GRANT]) |=> ctl_q[B_GRANT]);

    // R7
    grant_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_we && !sub_we && !ctl_q[B_LAYOUT] && !ctl_q[B_GRANT] && main_wdata[B_GRANT])
        |=> (own_q.sub_hi && own_q.sub_lo && !own_q.main_hi && !own_q.main_lo));

    // R13
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({own_q.main_hi, own_q.sub_hi}) && $onehot0({own_q.main_lo, own_q.sub_lo}));

    // R13
    own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_we && !sub_we) |=> $stable(own_q));
endmodule

// File: rtl/shram_view.sv
module shram_view
    import shram_pkg::*;
#(
    parameter int RAM_AW = 18
) (
    input  logic [CTL_W-1:0]  ctl,
    input  own_t              own,
    output logic [CTL_W-1:0]  main_rdata,
    output logic [CTL_W-1:0]  sub_rdata,
    output logic [RAM_AW-1:0] main_win_base,
    output logic [RAM_AW-1:0] sub_win_base
);
    localparam logic [RAM_AW-1:0] HALF_BASE = RAM_AW'(1) << (RAM_AW - 1);

    always_comb begin
        main_rdata    = ctl & MAIN_RMASK;
        sub_rdata     = ctl & SUB_RMASK;
        main_win_base = (own.main_hi && !own.main_lo) ? HALF_BASE : '0;
        sub_win_base  = (own.sub_hi && !own.sub_lo) ? HALF_BASE : '0;
    end

    // R9
    always_comb begin
        read_mask_chk: assert (main_rdata[4:3] == 2'b00 && sub_rdata[7:5] == 3'b000);
    end
endmodule

// File: rtl/shram_prog_guard.sv
module shram_prog_guard #(
    parameter int PROG_AW   = 19,
    parameter int REGION_AW = 17,
    localparam int BANK_W   = PROG_AW - REGION_AW,
    localparam int NREG     = 1 << BANK_W
) (
    input  logic [NREG-1:0]    prot_bits,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic               wr_req,
    input  logic [BANK_W-1:0]  region,
    output logic               wr_ok,
    output logic [PROG_AW-1:0] bank_base
);
    logic [NREG-1:0] region_hit;
    logic [NREG-1:0] region_open;

    for (genvar i = 0; i < NREG; i++) begin : g_region
        assign region_hit[i]  = (region == BANK_W'(i));
        assign region_open[i] = region_hit[i] & ~prot_bits[i];
    end

    assign wr_ok     = wr_req & (|region_open);
    assign bank_base = {bank_sel, {REGION_AW{1'b0}}};

    // R10
    always_comb begin
        prog_guard_chk: assert (!wr_ok || (wr_req && !prot_bits[region]));
    end
endmodule

// File: rtl/shram_owner_ctrl.sv
module shram_owner_ctrl
    import shram_pkg::*;
#(
    parameter int RAM_AW    = 18,
    parameter int PROG_AW   = 19,
    parameter int REGION_AW = 17,
    localparam int BANK_W   = PROG_AW - REGION_AW,
    localparam int NREG     = 1 << BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               main_we,
    input  logic [15:0]        main_wdata,
    output logic [15:0]        main_rdata,
    input  logic               sub_we,
    input  logic [15:0]        sub_wdata,
    output logic [15:0]        sub_rdata,
    input  logic               sub_prog_we,
    input  logic [BANK_W-1:0]  sub_prog_region,
    output logic               sub_prog_wr_ok,
    output logic [PROG_AW-1:0] prog_bank_base,
    output logic               main_hi,
    output logic               main_lo,
    output logic               sub_hi,
    output logic               sub_lo,
    output logic [RAM_AW-1:0]  main_win_base,
    output logic [RAM_AW-1:0]  sub_win_base
);
    logic [CTL_W-1:0] ctl;
    own_t             own;

    shram_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_we    (main_we),
        .main_wdata (main_wdata),
        .sub_we     (sub_we),
        .sub_wdata  (sub_wdata),
        .ctl_q      (ctl),
        .own_q      (own)
    );

    shram_view #(.RAM_AW(RAM_AW)) u_view (
        .ctl           (ctl),
        .own           (own),
        .main_rdata    (main_rdata),
        .sub_rdata     (sub_rdata),
        .main_win_base (main_win_base),
        .sub_win_base  (sub_win_base)
    );

    shram_prog_guard #(.PROG_AW(PROG_AW), .REGION_AW(REGION_AW)) u_guard (
        .prot_bits (ctl[PROT_LSB +: NREG]),
        .bank_sel  (ctl[BANK_LSB +: BANK_W]),
        .wr_req    (sub_prog_we),
        .region    (sub_prog_region),
        .wr_ok     (sub_prog_wr_ok),
        .bank_base (prog_bank_base)
    );

    assign main_hi = own.main_hi;
    assign main_lo = own.main_lo;
    assign sub_hi  = own.sub_hi;
    assign sub_lo  = own.sub_lo;
endmodule

// File: tb/sim_shram_owner_ctrl.sv
module sim_shram_owner_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [17:0] HALF = 18'h20000;

    typedef struct {
        string       tag;
        logic [15:0] ctl;
        logic [3:0]  own;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic main_we = 0, sub_we = 0, sub_prog_we = 0;
    logic [15:0] main_wdata = 0, sub_wdata = 0;
    logic [1:0]  sub_prog_region = 0;
    logic [15:0] main_rdata, sub_rdata;
    logic        sub_prog_wr_ok;
    logic [18:0] prog_bank_base;
    logic        main_hi, main_lo, sub_hi, sub_lo;
    logic [17:0] main_win_base, sub_win_base;

    int n_chk = 0, n_bad = 0;
    exp_t sb[$];
    logic [15:0] m_ctl;
    logic [3:0]  m_own;

    always #(CLK_PERIOD/2) clk = ~clk;

    shram_owner_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .main_we(main_we), .main_wdata(main_wdata), .main_rdata(main_rdata),
        .sub_we(sub_we), .sub_wdata(sub_wdata), .sub_rdata(sub_rdata),
        .sub_prog_we(sub_prog_we), .sub_prog_region(sub_prog_region),
        .sub_prog_wr_ok(sub_prog_wr_ok), .prog_bank_base(prog_bank_base),
        .main_hi(main_hi), .main_lo(main_lo), .sub_hi(sub_hi), .sub_lo(sub_lo),
        .main_win_base(main_win_base), .sub_win_base(sub_win_base)
    );

    function automatic logic [3:0] pick(input logic layout, input logic ret);
        if (!layout) return ret ? 4'b1100 : 4'b0011;
        return ret ? 4'b1001 : 4'b0110;
    endfunction

    // reference model from the requirements (R2..R8, R12)
    task automatic model(input logic mwe, input logic [15:0] mw, input logic swe, input logic [15:0] sw);
        logic [15:0] mid;
        mid = m_ctl;
        if (swe) begin
            mid[0] = sw[0]; mid[2] = sw[2]; mid[4:3] = sw[4:3];
            if (mid[0] != m_ctl[0] || mid[2] != m_ctl[2]) begin
                mid[1] = 1'b0;
                m_own  = pick(mid[2], mid[0]);
            end
        end
        m_ctl = mid;
        if (mwe) begin
            m_ctl[15:6] = mw[15:6];
            if (mid[2]) m_ctl[1] = ~mw[1];
            else begin
                m_ctl[1] = mw[1];
                if (!mid[1] && mw[1]) m_own = 4'b0011;
            end
        end
        m_ctl[5] = 1'b0;
    endtask

    task automatic step(input logic mwe, input logic [15:0] mw, input logic swe,
                        input logic [15:0] sw, input string tag);
        exp_t e;
        @(negedge clk);
        main_we = mwe; main_wdata = mw; sub_we = swe; sub_wdata = sw;
        model(mwe, mw, swe, sw);
        @(posedge clk);
        e.tag = tag; e.ctl = m_ctl; e.own = m_own;
        sb.push_back(e);
        #1;
        main_we = 0; sub_we = 0;
    endtask

    // monitor: compares after each update
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [17:0] emb, esb;
            e = sb.pop_front();
            emb = (e.own[3] && !e.own[2]) ? HALF : 18'h0;
            esb = (e.own[1] && !e.own[0]) ? HALF : 18'h0;
            n_chk++;
            if (main_rdata !== (e.ctl & 16'hFFE7) || sub_rdata !== (e.ctl & 16'hFF1F) ||
                {main_hi, main_lo, sub_hi, sub_lo} !== e.own ||
                main_win_base !== emb || sub_win_base !== esb) begin
                n_bad++;
                $display("FAIL %s: rd m=%h s=%h own=%b wb=%h/%h exp rd m=%h s=%h own=%b wb=%h/%h",
                    e.tag, main_rdata, sub_rdata, {main_hi, main_lo, sub_hi, sub_lo},
                    main_win_base, sub_win_base, e.ctl & 16'hFFE7, e.ctl & 16'hFF1F,
                    e.own, emb, esb);
            end
        end
    end

    task automatic prog_chk(input logic we, input logic [1:0] rg, input logic exp, input string tag);
        @(negedge clk);
        sub_prog_we = we; sub_prog_region = rg;
        #1;
        n_chk++;
        if (sub_prog_wr_ok !== exp) begin
            n_bad++;
            $display("FAIL %s: region %0d wr_ok=%b exp %b", tag, rg, sub_prog_wr_ok, exp);
        end
        sub_prog_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_ctl = 16'h0001; m_own = 4'b1100;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, "R1 reset");
        step(1, 16'hA5C0, 0, 0, "R3 main fields");
        step(0, 0, 1, 16'hFFFF, "R2 R6 sub to split ret1");
        step(0, 0, 1, 16'h001C, "R6 split ret0 swap");
        step(1, 16'hA5C0, 0, 0, "R8 split grant forced");
        step(1, 16'hA5C2, 0, 0, "R8 split grant inverted");
        step(0, 0, 1, 16'h0001, "R5 R4 whole ret1");
        step(1, 16'h0002, 0, 0, "R7 grant rise");
        step(0, 0, 1, 16'h0009, "R4 grant kept");
        step(0, 0, 1, 16'h0000, "R5 whole ret0");
        step(1, 16'h0002, 1, 16'h0001, "R12 ret change with grant rise");
        step(1, 16'h0000, 1, 16'h0005, "R12 sub-first ordering");
        step(1, 16'h0A80, 0, 0, "R13 R3 prot bank setup");
        @(negedge clk);
        n_chk++;
        if (prog_bank_base !== 19'h40000) begin
            n_bad++;
            $display("FAIL R11: bank base %h exp %h", prog_bank_base, 19'h40000);
        end
        prog_chk(1, 2'd0, 1'b1, "R10 region0");
        prog_chk(1, 2'd1, 1'b0, "R10 region1");
        prog_chk(1, 2'd2, 1'b1, "R10 region2");
        prog_chk(1, 2'd3, 1'b0, "R10 region3");
        prog_chk(0, 2'd0, 1'b0, "R10 no strobe");
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule